// File: doc/BRIEF.md
# Hypervisor Instruction Legality Checker

This block sits in the decode stage of a core with virtualization support. It takes one 32-bit instruction word per cycle, together with the privilege state of the hart, and recognises two groups of instructions. The first group is the guest-memory loads and stores, which read or write memory as the guest would see it. The second group is the two hypervisor address-translation fences: one for the guest's own stage and one for the guest-physical stage.

For each recognised instruction, the block reports the operation class, the access size, whether the load zero-extends, whether it is an execute-permission load, the fence kind and the register indices involved. It also reports whether the instruction may run, must raise an illegal-instruction exception, or must raise a virtual-instruction exception. The result is computed from the privilege level, the virtualization bit, the hypervisor's user-access enable and the machine virtual-memory trap bit.

The verdict is registered and comes out one cycle after the instruction is presented. Performing the access, invalidating translations and decoding other instructions are left to the neighbouring logic.

Top module: `hyp_insn_check`

## Requirements
- R1: All outputs are zero in reset. Each result appears on the cycle after `valid_i` is sampled high, with `valid_o` set. A cycle with `valid_i` low yields `valid_o`=0 and all other outputs zero.
- R2: A guest load is recognised when all of the following hold: opcode 1110011, funct3 100, and funct7 = 0110 followed by a 2-bit size and a 0. The size is 0 for byte, 1 for half, 2 for word and 3 for doubleword. The rs2 field selects the variant: 00000 is a sign-extending load, 00001 is a zero-extending load (byte, half or word only), and 00011 is an execute-permission zero-extending load (half or word only). The block reports `op_o`=1, `size_o`, `unsigned_o`, `exec_o`, `rd_o`=rd and `rs1_o`=rs1, with `rs2_o`=0.
- R3: A guest store is recognised when funct3 is 100, funct7 = 0110 followed by the size and a 1, and rd is 0. The block reports `op_o`=2, `size_o`, `rs1_o` (the address) and `rs2_o` (the data), with `rd_o`=0 and `unsigned_o`=`exec_o`=0.
- R4: With opcode 1110011, funct3 000 and rd 0, funct7 0010001 is the guest-stage fence (`fence_o`=1) and funct7 0110001 is the guest-physical-stage fence (`fence_o`=2). Both report `op_o`=3 with `rs1_o` and `rs2_o`. `fence_o` is 0 for every other class.
- R5: Any other word with opcode 1110011 and funct3 100 reports `op_o`=4 with `exc_o`=1 (illegal) and all field outputs zero. This holds in every privilege mode and every V, HU and TVM setting.
- R6: Any other instruction reports `op_o`=0 and `exc_o`=0.
- R7: A recognised load, store or fence presented with V=1 in S or U mode reports `exc_o`=2 (virtual-instruction).
- R8: With V=0, loads and stores are legal (`exc_o`=0) in M and S. In U mode they are legal only when HU=1 and illegal otherwise.
- R9: With V=0, the guest-stage fence is legal in M and S whatever TVM is, and illegal in U even when HU=1.
- R10: With V=0, the guest-physical-stage fence is legal in M even with TVM=1, legal in S only when TVM=0, and illegal in U.
- R11: Privilege encoding is 0 for U, 1 for S and 3 for M. V is ignored in M mode. The reserved code 2 is treated as U.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Instruction word is present |
| instr_i | input | 32 | Instruction word |
| priv_i | input | 2 | Current privilege (0 U, 1 S, 3 M) |
| virt_i | input | 1 | Virtualization bit V |
| hu_i | input | 1 | Hypervisor user-mode access enable |
| tvm_i | input | 1 | Machine virtual-memory trap bit |
| valid_o | output | 1 | Result is present |
| op_o | output | 3 | 0 none, 1 load, 2 store, 3 fence, 4 reserved encoding |
| size_o | output | 2 | Access size code |
| unsigned_o | output | 1 | Load zero-extends |
| exec_o | output | 1 | Load checks execute permission |
| fence_o | output | 2 | 0 none, 1 guest stage, 2 guest-physical stage |
| rd_o | output | 5 | Destination register index |
| rs1_o | output | 5 | First source register index |
| rs2_o | output | 5 | Second source register index |
| exc_o | output | 2 | 0 none, 1 illegal-instruction, 2 virtual-instruction |

## Verification
Several rules are checked by assertions on every cycle:
- an idle cycle is quiet;
- a reserved encoding is always illegal;
- a non-hypervisor instruction never raises an exception;
- only V=1 outside M mode can yield a virtual-instruction verdict;
- the fence kind agrees with the operation class;
- execute-permission loads are half or word and zero-extending;
- a legal guest-physical-stage fence was never issued from S mode with TVM set;
- a legal user-mode access always had HU set.

Other behaviour can only be shown by the bench's scenarios. This covers the exact bit patterns that select each size and variant, the register indices reported, and the full privilege, V, HU and TVM matrix for each group.

// File: rtl/hyp_chk_pkg.sv
package hyp_chk_pkg;
    localparam int ILEN     = 32;
    localparam int REG_W    = 5;
    localparam int OPC_W    = 7;
    localparam int F3_W     = 3;
    localparam int F7_W     = 7;
    localparam int SIZE_W   = 2;

    localparam logic [OPC_W-1:0] SYS_OPC   = 7'b1110011;
    localparam logic [F3_W-1:0]  F3_HYP    = 3'b100;
    localparam logic [F3_W-1:0]  F3_PRIV   = 3'b000;
    localparam logic [3:0]       HYP_F7_HI = 4'b0110;
    localparam logic [F7_W-1:0]  F7_FNC_VS = 7'b0010001;
    localparam logic [F7_W-1:0]  F7_FNC_G  = 7'b0110001;
    localparam logic [REG_W-1:0] LD_SEXT   = 5'd0;
    localparam logic [REG_W-1:0] LD_ZEXT   = 5'd1;
    localparam logic [REG_W-1:0] LD_EXEC   = 5'd3;

    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_LOAD  = 3'd1,
        OP_STORE = 3'd2,
        OP_FENCE = 3'd3,
        OP_BAD   = 3'd4
    } op_e;

    typedef enum logic [1:0] {
        FN_NONE = 2'd0,
        FN_VS   = 2'd1,
        FN_G    = 2'd2
    } fence_e;

    typedef enum logic [1:0] {
        EX_NONE = 2'd0,
        EX_ILL  = 2'd1,
        EX_VIRT = 2'd2
    } exc_e;

    typedef enum logic [1:0] {
        PR_U   = 2'd0,
        PR_S   = 2'd1,
        PR_RSV = 2'd2,
        PR_M   = 2'd3
    } priv_e;

    typedef struct packed {
        op_e               op;
        logic [SIZE_W-1:0] size;
        logic              uns;
        logic              exec;
        fence_e            fence;
        logic [REG_W-1:0]  rd;
        logic [REG_W-1:0]  rs1;
        logic [REG_W-1:0]  rs2;
    } dec_t;

    typedef struct packed {
        logic valid;
        dec_t dec;
        exc_e exc;
    } res_t;
endpackage

// File: rtl/hyp_decode.sv
module hyp_decode
    import hyp_chk_pkg::*;
(
    input  logic [ILEN-1:0] instr,
    output dec_t            dec
);
    logic [OPC_W-1:0]  opc;
    logic [REG_W-1:0]  rd;
    logic [F3_W-1:0]   f3;
    logic [REG_W-1:0]  rs1;
    logic [REG_W-1:0]  rs2;
    logic [F7_W-1:0]   f7;
    logic [SIZE_W-1:0] sz;
    logic              is_hyp;
    logic              is_priv;

    assign opc     = instr[6:0];
    assign rd      = instr[11:7];
    assign f3      = instr[14:12];
    assign rs1     = instr[19:15];
    assign rs2     = instr[24:20];
    assign f7      = instr[31:25];
    assign sz      = f7[2:1];
    assign is_hyp  = (opc == SYS_OPC) && (f3 == F3_HYP);
    assign is_priv = (opc == SYS_OPC) && (f3 == F3_PRIV) && (rd == '0);

    always_comb begin
        dec = '0;
        if (is_hyp) begin
            dec.op = OP_BAD;
            if (f7[6:3] == HYP_F7_HI) begin
                if (f7[0]) begin
                    if (rd == '0) begin
                        dec.op   = OP_STORE;
                        dec.size = sz;
                        dec.rs1  = rs1;
                        dec.rs2  = rs2;
                    end
                end else if (rs2 == LD_SEXT) begin
                    dec.op   = OP_LOAD;
                    dec.size = sz;
                    dec.rd   = rd;
                    dec.rs1  = rs1;
                end else if (rs2 == LD_ZEXT && sz != 2'b11) begin
                    dec.op   = OP_LOAD;
                    dec.size = sz;
                    dec.uns  = 1'b1;
                    dec.rd   = rd;
                    dec.rs1  = rs1;
                end else if (rs2 == LD_EXEC && (sz == 2'b01 || sz == 2'b10)) begin
                    dec.op   = OP_LOAD;
                    dec.size = sz;
                    dec.uns  = 1'b1;
                    dec.exec = 1'b1;
                    dec.rd   = rd;
                    dec.rs1  = rs1;
                end
            end
        end else if (is_priv && (f7 == F7_FNC_VS || f7 == F7_FNC_G)) begin
            dec.op    = OP_FENCE;
            dec.fence = (f7 == F7_FNC_G) ? FN_G : FN_VS;
            dec.rs1   = rs1;
            dec.rs2   = rs2;
        end
    end
endmodule

// File: rtl/hyp_legal.sv
module hyp_legal
    import hyp_chk_pkg::*;
(
    input  op_e        op,
    input  fence_e     fence,
    input  logic [1:0] priv,
    input  logic       virt,
    input  logic       hu,
    input  logic       tvm,
    output exc_e       exc
);
    logic is_m;
    logic is_s;
    logic is_u;
    logic v_eff;

    assign is_m  = (priv == PR_M);
    assign is_s  = (priv == PR_S);
    assign is_u  = !is_m && !is_s;
    assign v_eff = virt && !is_m;

    always_comb begin
        exc = EX_NONE;
        case (op)
            OP_BAD: exc = EX_ILL;
            OP_LOAD, OP_STORE: begin
                if (v_eff)
                    exc = EX_VIRT;
                else if (is_u && !hu)
                    exc = EX_ILL;
            end
            OP_FENCE: begin
                if (v_eff)
                    exc = EX_VIRT;
                else if (is_u)
                    exc = EX_ILL;
                else if (fence == FN_G && is_s && tvm)
                    exc = EX_ILL;
            end
            default: exc = EX_NONE;
        endcase
    end
endmodule

// File: rtl/hyp_insn_check.sv
module hyp_insn_check
    import hyp_chk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid_i,
    input  logic [ILEN-1:0]  instr_i,
    input  logic [1:0]       priv_i,
    input  logic             virt_i,
    input  logic             hu_i,
    input  logic             tvm_i,
    output logic             valid_o,
    output logic [2:0]       op_o,
    output logic [SIZE_W-1:0] size_o,
    output logic             unsigned_o,
    output logic             exec_o,
    output logic [1:0]       fence_o,
    output logic [REG_W-1:0] rd_o,
    output logic [REG_W-1:0] rs1_o,
    output logic [REG_W-1:0] rs2_o,
    output logic [1:0]       exc_o
);
    dec_t dec_w;
    exc_e exc_w;
    res_t res_d;
    res_t res_q;

    hyp_decode u_dec (
        .instr (instr_i),
        .dec   (dec_w)
    );

    hyp_legal u_legal (
        .op    (dec_w.op),
        .fence (dec_w.fence),
        .priv  (priv_i),
        .virt  (virt_i),
        .hu    (hu_i),
        .tvm   (tvm_i),
        .exc   (exc_w)
    );

    always_comb begin
        res_d = '0;
        if (valid_i) begin
            res_d.valid = 1'b1;
            res_d.dec   = dec_w;
            res_d.exc   = exc_w;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            res_q <= '0;
        else
            res_q <= res_d;
    end

    assign valid_o    = res_q.valid;
    assign op_o       = res_q.dec.op;
    assign size_o     = res_q.dec.size;
    assign unsigned_o = res_q.dec.uns;
    assign exec_o     = res_q.dec.exec;
    assign fence_o    = res_q.dec.fence;
    assign rd_o       = res_q.dec.rd;
    assign rs1_o      = res_q.dec.rs1;
    assign rs2_o      = res_q.dec.rs2;
    assign exc_o      = res_q.exc;
endmodule

// File: rtl/hyp_insn_check_sva.sv
module hyp_insn_check_sva (
    input logic       clk,
    input logic       rst_n,
    input logic       valid_i,
    input logic [1:0] priv_i,
    input logic       virt_i,
    input logic       hu_i,
    input logic       tvm_i,
    input logic       valid_o,
    input logic [2:0] op_o,
    input logic [1:0] size_o,
    input logic       unsigned_o,
    input logic       exec_o,
    input logic [1:0] fence_o,
    input logic [1:0] exc_o
);
    AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> valid_o); // R1
    AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> !valid_o); // R1
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> (op_o == 3'd0 && exc_o == 2'd0 && fence_o == 2'd0)); // R1
    AST_EXEC_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        exec_o |-> (op_o == 3'd1 && unsigned_o && (size_o == 2'd1 || size_o == 2'd2))); // R2
    AST_STORE_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (op_o == 3'd2) |-> (!unsigned_o && !exec_o)); // R3
    AST_FENCE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        (op_o == 3'd3) == (fence_o != 2'd0)); // R4
    AST_BAD_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (op_o == 3'd4) |-> (exc_o == 2'd1)); // R5
    AST_NONE_NO_EXC: assert property (@(posedge clk) disable iff (!rst_n)
        (op_o == 3'd0) |-> (exc_o == 2'd0)); // R6
    AST_VIRT_NEEDS_V: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && (!virt_i || priv_i == 2'd3)) |=> (exc_o != 2'd2)); // R7
    AST_USER_NEEDS_HU: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !virt_i && priv_i == 2'd0 && !hu_i) |=> (exc_o != 2'd0 || op_o == 3'd0)); // R8
    AST_GFENCE_TVM: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && priv_i == 2'd1 && tvm_i) |=> !(fence_o == 2'd2 && exc_o == 2'd0)); // R10
endmodule

bind hyp_insn_check hyp_insn_check_sva u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .valid_i    (valid_i),
    .priv_i     (priv_i),
    .virt_i     (virt_i),
    .hu_i       (hu_i),
    .tvm_i      (tvm_i),
    .valid_o    (valid_o),
    .op_o       (op_o),
    .size_o     (size_o),
    .unsigned_o (unsigned_o),
    .exec_o     (exec_o),
    .fence_o    (fence_o),
    .exc_o      (exc_o)
);

// File: tb/hyp_insn_check_test.sv
module hyp_insn_check_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;
    localparam logic [6:0] OPC = 7'b1110011;

    localparam logic [31:0] I_LDB   = {7'b0110000, 5'd0, 5'd10, 3'b100, 5'd5, OPC};
    localparam logic [31:0] I_LDWU  = {7'b0110100, 5'd1, 5'd11, 3'b100, 5'd6, OPC};
    localparam logic [31:0] I_LXHU  = {7'b0110010, 5'd3, 5'd12, 3'b100, 5'd8, OPC};
    localparam logic [31:0] I_LDD   = {7'b0110110, 5'd0, 5'd13, 3'b100, 5'd9, OPC};
    localparam logic [31:0] I_STW   = {7'b0110101, 5'd7, 5'd10, 3'b100, 5'd0, OPC};
    localparam logic [31:0] I_STD   = {7'b0110111, 5'd2, 5'd1,  3'b100, 5'd0, OPC};
    localparam logic [31:0] I_FVS   = {7'b0010001, 5'd3, 5'd4,  3'b000, 5'd0, OPC};
    localparam logic [31:0] I_FG    = {7'b0110001, 5'd3, 5'd4,  3'b000, 5'd0, OPC};
    localparam logic [31:0] I_BADX  = {7'b0110000, 5'd3, 5'd4,  3'b100, 5'd2, OPC};
    localparam logic [31:0] I_BADDU = {7'b0110110, 5'd1, 5'd4,  3'b100, 5'd2, OPC};
    localparam logic [31:0] I_BADST = {7'b0110101, 5'd7, 5'd4,  3'b100, 5'd2, OPC};
    localparam logic [31:0] I_BADF7 = {7'b0000000, 5'd0, 5'd4,  3'b100, 5'd2, OPC};
    localparam logic [31:0] I_ADD   = 32'h00b50533;
    localparam logic [31:0] I_SFN   = {7'b0001001, 5'd3, 5'd4,  3'b000, 5'd0, OPC};

    typedef struct packed {
        logic [31:0] ins;
        logic [1:0]  priv;
        logic        v;
        logic        hu;
        logic        tvm;
        logic [2:0]  op;
        logic [1:0]  exc;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t VECS [NV] = '{
        '{I_LDB,   2'd1, 1'b0, 1'b0, 1'b0, 3'd1, 2'd0, 4'd8},  // R8 S legal
        '{I_LDB,   2'd0, 1'b0, 1'b0, 1'b0, 3'd1, 2'd1, 4'd8},  // R8 U, HU=0
        '{I_LDB,   2'd0, 1'b0, 1'b1, 1'b0, 3'd1, 2'd0, 4'd8},  // R8 U, HU=1
        '{I_LDWU,  2'd1, 1'b1, 1'b0, 1'b0, 3'd1, 2'd2, 4'd7},  // R7 VS
        '{I_LDWU,  2'd0, 1'b1, 1'b1, 1'b0, 3'd1, 2'd2, 4'd7},  // R7 VU
        '{I_STW,   2'd3, 1'b0, 1'b0, 1'b1, 3'd2, 2'd0, 4'd8},  // R8 M
        '{I_STW,   2'd0, 1'b0, 1'b0, 1'b0, 3'd2, 2'd1, 4'd8},  // R8 store U HU=0
        '{I_STD,   2'd0, 1'b0, 1'b1, 1'b0, 3'd2, 2'd0, 4'd8},  // R8
        '{I_LXHU,  2'd3, 1'b1, 1'b0, 1'b0, 3'd1, 2'd0, 4'd11}, // R11 V ignored in M
        '{I_FVS,   2'd1, 1'b0, 1'b0, 1'b1, 3'd3, 2'd0, 4'd9},  // R9 TVM no effect
        '{I_FVS,   2'd0, 1'b0, 1'b1, 1'b0, 3'd3, 2'd1, 4'd9},  // R9 U illegal
        '{I_FVS,   2'd1, 1'b1, 1'b0, 1'b0, 3'd3, 2'd2, 4'd7},  // R7
        '{I_FG,    2'd1, 1'b0, 1'b0, 1'b0, 3'd3, 2'd0, 4'd10}, // R10
        '{I_FG,    2'd1, 1'b0, 1'b0, 1'b1, 3'd3, 2'd1, 4'd10}, // R10 TVM trap
        '{I_FG,    2'd3, 1'b0, 1'b0, 1'b1, 3'd3, 2'd0, 4'd10}, // R10 M
        '{I_FG,    2'd0, 1'b0, 1'b1, 1'b0, 3'd3, 2'd1, 4'd10}, // R10 U
        '{I_FG,    2'd0, 1'b1, 1'b1, 1'b1, 3'd3, 2'd2, 4'd7},  // R7
        '{I_BADX,  2'd3, 1'b0, 1'b0, 1'b0, 3'd4, 2'd1, 4'd5},  // R5
        '{I_BADDU, 2'd1, 1'b1, 1'b0, 1'b0, 3'd4, 2'd1, 4'd5},  // R5 not virtual
        '{I_BADST, 2'd3, 1'b0, 1'b1, 1'b0, 3'd4, 2'd1, 4'd5},  // R5
        '{I_BADF7, 2'd0, 1'b0, 1'b1, 1'b0, 3'd4, 2'd1, 4'd5},  // R5
        '{I_ADD,   2'd1, 1'b0, 1'b0, 1'b0, 3'd0, 2'd0, 4'd6},  // R6
        '{I_SFN,   2'd1, 1'b1, 1'b0, 1'b0, 3'd0, 2'd0, 4'd6},  // R6
        '{I_LDB,   2'd2, 1'b0, 1'b0, 1'b0, 3'd1, 2'd1, 4'd11}, // R11 reserved as U
        '{I_LDB,   2'd2, 1'b0, 1'b1, 1'b0, 3'd1, 2'd0, 4'd11}, // R11
        '{I_LDD,   2'd1, 1'b0, 1'b0, 1'b0, 3'd1, 2'd0, 4'd2}   // R2
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic [31:0] instr_i = '0;
    logic [1:0]  priv_i = '0;
    logic        virt_i = 1'b0;
    logic        hu_i = 1'b0;
    logic        tvm_i = 1'b0;
    logic        valid_o, unsigned_o, exec_o;
    logic [2:0]  op_o;
    logic [1:0]  size_o, fence_o, exc_o;
    logic [4:0]  rd_o, rs1_o, rs2_o;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hyp_insn_check uut (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .instr_i(instr_i),
        .priv_i(priv_i), .virt_i(virt_i), .hu_i(hu_i), .tvm_i(tvm_i),
        .valid_o(valid_o), .op_o(op_o), .size_o(size_o), .unsigned_o(unsigned_o),
        .exec_o(exec_o), .fence_o(fence_o), .rd_o(rd_o), .rs1_o(rs1_o),
        .rs2_o(rs2_o), .exc_o(exc_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic apply(input logic [31:0] ins, input logic [1:0] pr,
                         input logic v, input logic h, input logic t);
        @(negedge clk);
        valid_i = 1'b1; instr_i = ins; priv_i = pr; virt_i = v; hu_i = h; tvm_i = t;
        @(negedge clk);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual=expired expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset valid", 32'(valid_o), 32'd0);
        check("R1 reset op", 32'(op_o), 32'd0);
        check("R1 reset exc", 32'(exc_o), 32'd0);
        check("R1 reset fields", {17'd0, rd_o, rs1_o, rs2_o}, 32'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i].ins, VECS[i].priv, VECS[i].v, VECS[i].hu, VECS[i].tvm);
            check($sformatf("R%0d vec %0d op", VECS[i].req, i), 32'(op_o), 32'(VECS[i].op));
            check($sformatf("R%0d vec %0d exc", VECS[i].req, i), 32'(exc_o), 32'(VECS[i].exc));
        end

        // R2 field decode
        apply(I_LDB, 2'd3, 1'b0, 1'b0, 1'b0);
        check("R2 byte fields", {size_o, unsigned_o, exec_o, rd_o, rs1_o, rs2_o},
              {2'd0, 1'b0, 1'b0, 5'd5, 5'd10, 5'd0});
        apply(I_LDWU, 2'd3, 1'b0, 1'b0, 1'b0);
        check("R2 word unsigned", {size_o, unsigned_o, exec_o, rd_o, rs1_o},
              {2'd2, 1'b1, 1'b0, 5'd6, 5'd11});
        apply(I_LXHU, 2'd3, 1'b0, 1'b0, 1'b0);
        check("R2 exec half", {size_o, unsigned_o, exec_o, rd_o, rs1_o, rs2_o},
              {2'd1, 1'b1, 1'b1, 5'd8, 5'd12, 5'd0});
        apply(I_LDD, 2'd3, 1'b0, 1'b0, 1'b0);
        check("R2 double", {size_o, unsigned_o}, {2'd3, 1'b0});
        // R3 store fields
        apply(I_STW, 2'd1, 1'b0, 1'b0, 1'b0);
        check("R3 store fields", {size_o, unsigned_o, exec_o, rd_o, rs1_o, rs2_o},
              {2'd2, 1'b0, 1'b0, 5'd0, 5'd10, 5'd7});
        // R4 fence kinds
        apply(I_FVS, 2'd1, 1'b0, 1'b0, 1'b0);
        check("R4 vs fence", {fence_o, rs1_o, rs2_o}, {2'd1, 5'd4, 5'd3});
        apply(I_FG, 2'd3, 1'b0, 1'b0, 1'b0);
        check("R4 g fence", {fence_o, rs1_o, rs2_o}, {2'd2, 5'd4, 5'd3});
        apply(I_LDB, 2'd3, 1'b0, 1'b0, 1'b0);
        check("R4 no fence on load", 32'(fence_o), 32'd0);
        // R5 reserved fields zero
        apply(I_BADST, 2'd3, 1'b0, 1'b0, 1'b0);
        check("R5 bad fields", {size_o, rd_o, rs1_o, rs2_o}, 17'd0);

        // R1 idle after a valid word
        @(negedge clk);
        valid_i = 1'b0; instr_i = I_LDB;
        @(negedge clk);
        check("R1 idle valid", 32'(valid_o), 32'd0);
        check("R1 idle op", 32'(op_o), 32'd0);
        check("R1 idle fields", {rd_o, rs1_o}, 32'd0);
        valid_i = 1'b1;
        @(negedge clk);
        check("R1 valid returns", {valid_o, op_o}, {1'b1, 3'd1});

        finish_run();
    end
endmodule